// File: doc/BRIEF.md
# Multi-drop serial receiver with masked address filter

This block receives asynchronous serial frames from a line that is shared by several nodes. A sampling strobe at a fixed multiple of the bit rate (sixteen by default) comes with the line. The block validates each start bit at its centre and collects eight data bits, least significant first. In nine-bit mode it also collects a ninth bit. Then it samples the stop bit. A completed frame is placed in a receive buffer and a receive flag is raised for the host, unless the address filter rejects the frame.

With nine-bit mode on and the multi-drop enable input high, a frame whose ninth bit is 1 is an address frame. It is compared with a programmed node address. Address bits whose mask bit is 0 are ignored in that comparison. It is also compared with a broadcast pattern, which is the OR of address and mask. In that pattern only the 1 bits have to match. A matching address frame is delivered and selects the node. Data frames (ninth bit 0) are delivered only while the node is selected.

A bad stop bit sets a sticky framing-error flag. That flag shares one control bit position with the nine-bit mode bit, and a select input picks which of the two is read and written there.

Top module: `uart_mp_rx`

## Requirements
- R1: After reset, rx_data is 0, rx_bit9 is 0, rx_flag is 0, fe_flag is 0, overrun_cnt is 0, nine-bit mode is off and the node is not selected.
- R2: A frame is a low start bit, then eight data bits least significant first, then a stop bit, each lasting OVS strobes. When it completes, rx_data holds the byte and rx_flag is set. In eight-bit mode rx_bit9 holds the sampled stop bit.
- R3: With sh_sel=0, a pulse on sh_wr loads sh_wdata into the nine-bit mode bit, and sh_rdata shows that bit. In nine-bit mode a ninth bit follows the eight data bits, and rx_bit9 holds it.
- R4: A low level is checked again after OVS/2 strobes. If the line is high again at that point, it is ignored: no frame, no flag change and no buffer change.
- R5: A stop bit sampled as 0 sets fe_flag, and the frame is still delivered. fe_flag stays set until it is written through sh_wr with sh_sel=1, and sh_rdata shows fe_flag while sh_sel=1.
- R6: With nine-bit mode on and mp_en=1, an address frame (ninth bit 1) is delivered when its byte matches slave_addr on every bit where slave_mask is 1. Such a frame also selects the node.
- R7: With nine-bit mode on and mp_en=1, an address frame is also delivered and selects the node when its byte has a 1 at every bit where (slave_addr OR slave_mask) is 1.
- R8: With nine-bit mode on and mp_en=1, an address frame matching neither pattern leaves rx_flag and rx_data unchanged and deselects the node.
- R9: With nine-bit mode on and mp_en=1, a data frame (ninth bit 0) is delivered only while the node is selected. Driving mp_en to 0 deselects the node, and while mp_en is 0 all frames are delivered.
- R10: A frame that would be delivered while rx_flag is set leaves rx_data and rx_bit9 unchanged and increments overrun_cnt, which wraps modulo 2^OVR_W.
- R11: rx_flag stays set until a one-cycle pulse on flag_clr clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, OVS per bit time |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| slave_addr | input | DATA_W | Node address |
| slave_mask | input | DATA_W | Address mask, 0 marks a don't-care bit |
| mp_en | input | 1 | Multi-drop filtering enable |
| flag_clr | input | 1 | Clears rx_flag |
| sh_wr | input | 1 | Write strobe for the shared control bit |
| sh_sel | input | 1 | 1 selects the framing-error flag, 0 the nine-bit mode bit |
| sh_wdata | input | 1 | Value written to the shared position |
| rx_data | output | DATA_W | Received byte |
| rx_bit9 | output | 1 | Ninth bit (stop bit in eight-bit mode) |
| rx_flag | output | 1 | Receive flag |
| fe_flag | output | 1 | Sticky framing error |
| sh_rdata | output | 1 | Read value of the shared position |
| overrun_cnt | output | OVR_W | Count of frames dropped while rx_flag was set |

## Verification
The bench uses the default DATA_W=8, OVS=16 and SYNC_STAGES=2, with the strobe held high so that one bit lasts sixteen clocks. It narrows OVR_W to 2, so four dropped frames are enough to show the overrun counter wrapping. The address 0xF1 with mask 0xF5 gives the don't-care pattern 1111 X0X1 and the broadcast pattern 0xF5. With these values a single byte can match the node address only, match the broadcast pattern only, or miss by one bit.

// File: rtl/uart_mp_rx_pkg.sv
// Package: shared types and the address comparison used by the multi-drop
// receiver. Assumes the address and mask share one width.
package uart_mp_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    localparam int ADDR_W = 8;

    // Node match: every bit whose mask bit is 1 must equal the address bit.
    function automatic logic node_match(input logic [ADDR_W-1:0] byte_in,
                                        input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] mask);
        return ((byte_in ^ addr) & mask) == '0;
    endfunction

    // Broadcast match: every 1 of (addr | mask) must be 1 in the byte.
    function automatic logic bcast_match(input logic [ADDR_W-1:0] byte_in,
                                         input logic [ADDR_W-1:0] addr,
                                         input logic [ADDR_W-1:0] mask);
        logic [ADDR_W-1:0] pat;
        pat = addr | mask;
        return (byte_in & pat) == pat;
    endfunction

endpackage

// File: rtl/rxa_sync.sv
// Module: multi-flop synchronizer for the asynchronous serial line.
// Assumes STAGES >= 2; the flops reset to the line's idle level.
module rxa_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxa_deframer.sv
// Module: oversampling deframer. It detects a start edge, confirms it at
// mid-bit and samples each following bit at its centre. It produces a
// one-cycle frame pulse with the byte, the ninth (or stop) bit and the stop
// bit value. Assumes OVS is even and at least 4, and that rx_s is
// already synchronized.
module rxa_deframer
    import uart_mp_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              nine_mode,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_bit9,
    output logic              frm_stop_ok
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2 - 1;
    localparam int NB  = DATA_W + 1;
    localparam int IW  = $clog2(NB);

    rx_state_t       state;
    logic [CW-1:0]   cnt;
    logic [IW-1:0]   idx;
    logic [NB-1:0]   bits;
    logic            nine_l;
    logic            stop_l;
    logic            valid_q;
    logic [IW-1:0]   last_idx;

    // Index of the last bit before the stop bit, set by the latched mode.
    always_comb begin
        last_idx = nine_l ? IW'(NB - 1) : IW'(DATA_W - 1);
    end

    // Frame state machine: start check, bit sampling, stop sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            bits    <= '0;
            nine_l  <= 1'b0;
            stop_l  <= 1'b1;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (tick && !rx_s) begin
                        state  <= RX_START;
                        cnt    <= '0;
                        nine_l <= nine_mode;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == CW'(MID)) begin
                            cnt   <= '0;
                            idx   <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt       <= '0;
                            bits[idx] <= rx_s;
                            idx       <= idx + 1'b1;
                            if (idx == last_idx) state <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt     <= '0;
                            stop_l  <= rx_s;
                            valid_q <= 1'b1;
                            state   <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign frm_valid   = valid_q;
    assign frm_data    = bits[DATA_W-1:0];
    assign frm_bit9    = nine_l ? bits[NB-1] : stop_l;
    assign frm_stop_ok = stop_l;
endmodule

// File: rtl/rxa_addr_filter.sv
// Module: multi-drop address filter. It decides whether a completed frame
// reaches the buffer, and it keeps the "node selected" state. Filtering is
// active only in nine-bit mode with mp_en high. Assumes DATA_W equals the
// package address width.
module rxa_addr_filter
    import uart_mp_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_bit9,
    input  logic              nine_mode,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] slave_mask,
    output logic              accept
);
    logic mp_on;
    logic hit;
    logic selected;

    // Combine the mode gate with the node and broadcast comparisons.
    always_comb begin
        mp_on  = nine_mode && mp_en;
        hit    = node_match(frm_data, slave_addr, slave_mask) ||
                 bcast_match(frm_data, slave_addr, slave_mask);
        accept = !mp_on || (frm_bit9 ? hit : selected);
    end

    // Track selection: set or dropped by address frames, cleared when off.
    always_ff @(posedge clk) begin
        if (!rst_n)                      selected <= 1'b0;
        else if (!mp_on)                 selected <= 1'b0;
        else if (frm_valid && frm_bit9)  selected <= hit;
    end
endmodule

// File: rtl/uart_mp_rx.sv
// Module: top of the multi-drop serial receiver. It holds the receive
// buffer, the receive flag, the overrun counter, the sticky framing error
// flag and the shared control bit, which is the mode bit or the framing
// error flag depending on sh_sel. Assumes os_tick is synchronous to clk.
module uart_mp_rx
    import uart_mp_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2,
    parameter int OVR_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] slave_mask,
    input  logic              mp_en,
    input  logic              flag_clr,
    input  logic              sh_wr,
    input  logic              sh_sel,
    input  logic              sh_wdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_flag,
    output logic              fe_flag,
    output logic              sh_rdata,
    output logic [OVR_W-1:0]  overrun_cnt
);
    logic              rx_s;
    logic              mode9;
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_bit9;
    logic              frm_stop_ok;
    logic              accept;
    logic              flag_busy;

    rxa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rx_s)
    );

    rxa_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_defr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .rx_s        (rx_s),
        .nine_mode   (mode9),
        .frm_valid   (frm_valid),
        .frm_data    (frm_data),
        .frm_bit9    (frm_bit9),
        .frm_stop_ok (frm_stop_ok)
    );

    rxa_addr_filter #(.DATA_W(DATA_W)) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .frm_data   (frm_data),
        .frm_bit9   (frm_bit9),
        .nine_mode  (mode9),
        .mp_en      (mp_en),
        .slave_addr (slave_addr),
        .slave_mask (slave_mask),
        .accept     (accept)
    );

    // The buffer counts as busy unless software clears it in this cycle.
    always_comb begin
        flag_busy = rx_flag && !flag_clr;
    end

    // Receive buffer, flag and overrun counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_bit9     <= 1'b0;
            rx_flag     <= 1'b0;
            overrun_cnt <= '0;
        end else if (frm_valid && accept) begin
            if (flag_busy) begin
                overrun_cnt <= overrun_cnt + 1'b1;
            end else begin
                rx_data <= frm_data;
                rx_bit9 <= frm_bit9;
                rx_flag <= 1'b1;
            end
        end else if (flag_clr) begin
            rx_flag <= 1'b0;
        end
    end

    // Sticky framing error: a bad stop bit wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                       fe_flag <= 1'b0;
        else if (frm_valid && !frm_stop_ok) fe_flag <= 1'b1;
        else if (sh_wr && sh_sel)         fe_flag <= sh_wdata;
    end

    // Nine-bit mode bit, written through the shared position with sh_sel=0.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mode9 <= 1'b0;
        else if (sh_wr && !sh_sel)  mode9 <= sh_wdata;
    end

    assign sh_rdata = sh_sel ? fe_flag : mode9;
endmodule

// File: rtl/uart_mp_rx_chk.sv
// Module: assertion checker for uart_mp_rx, attached with bind. It watches
// the ports and the deframer's frame pulse.
module uart_mp_rx_chk
    import uart_mp_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_clr,
    input logic              sh_wr,
    input logic              sh_sel,
    input logic              mp_en,
    input logic              mode9,
    input logic [DATA_W-1:0] slave_addr,
    input logic [DATA_W-1:0] slave_mask,
    input logic              frm_valid,
    input logic [DATA_W-1:0] frm_data,
    input logic              frm_bit9,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              rx_flag,
    input logic              fe_flag,
    input logic [OVR_W-1:0]  overrun_cnt
);
    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !flag_clr) |=> rx_flag);

    // R10
    buf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && !flag_clr) |=> ($stable(rx_data) && $stable(rx_bit9)));

    // R10
    ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_cnt != $past(overrun_cnt)) |->
            (overrun_cnt == $past(overrun_cnt) + 1'b1));

    // R5
    fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_flag && !(sh_wr && sh_sel)) |=> fe_flag);

    // R2
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(frm_valid));

    // R8
    addr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && mode9 && mp_en && frm_bit9 && !rx_flag &&
         !node_match(frm_data, slave_addr, slave_mask) &&
         !bcast_match(frm_data, slave_addr, slave_mask)) |=> !rx_flag);
endmodule

bind uart_mp_rx uart_mp_rx_chk #(.DATA_W(DATA_W), .OVR_W(OVR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_clr    (flag_clr),
    .sh_wr       (sh_wr),
    .sh_sel      (sh_sel),
    .mp_en       (mp_en),
    .mode9       (mode9),
    .slave_addr  (slave_addr),
    .slave_mask  (slave_mask),
    .frm_valid   (frm_valid),
    .frm_data    (frm_data),
    .frm_bit9    (frm_bit9),
    .rx_data     (rx_data),
    .rx_bit9     (rx_bit9),
    .rx_flag     (rx_flag),
    .fe_flag     (fe_flag),
    .overrun_cnt (overrun_cnt)
);

// File: tb/test_uart_mp_rx.sv
module test_uart_mp_rx;
    localparam int OVR_W = 2;
    localparam logic [7:0] ADDR = 8'hF1;
    localparam logic [7:0] MASK = 8'hF5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b1;
    logic rxd = 1'b1;
    logic [7:0] slave_addr = ADDR;
    logic [7:0] slave_mask = MASK;
    logic mp_en = 1'b0;
    logic flag_clr = 1'b0;
    logic sh_wr = 1'b0;
    logic sh_sel = 1'b0;
    logic sh_wdata = 1'b0;
    logic [7:0] rx_data;
    logic rx_bit9, rx_flag, fe_flag, sh_rdata;
    logic [OVR_W-1:0] overrun_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_en = 0;
    bit done = 0;

    // behavioural reference state
    logic [7:0] m_data = 0;
    logic m_b9 = 0, m_flag = 0, m_fe = 0, m_mode9 = 0, m_sel_node = 0;
    int m_ovr = 0;

    always #4 clk = ~clk;

    uart_mp_rx #(.DATA_W(8), .OVS(16), .SYNC_STAGES(2), .OVR_W(OVR_W)) i_uart_mp_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .slave_addr(slave_addr), .slave_mask(slave_mask), .mp_en(mp_en),
        .flag_clr(flag_clr), .sh_wr(sh_wr), .sh_sel(sh_sel), .sh_wdata(sh_wdata),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
        .fe_flag(fe_flag), .sh_rdata(sh_rdata), .overrun_cnt(overrun_cnt)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // per-clock comparison against the reference, away from the edge
    always @(posedge clk) begin
        #2;
        if (cmp_en && rst_n) begin
            n_chk++;
            if (rx_data !== m_data) begin n_fail++; $display("FAIL R2 rx_data actual %0h expected %0h", rx_data, m_data); end
            if (rx_bit9 !== m_b9) begin n_fail++; $display("FAIL R3 rx_bit9 actual %0d expected %0d", rx_bit9, m_b9); end
            if (rx_flag !== m_flag) begin n_fail++; $display("FAIL R11 rx_flag actual %0d expected %0d", rx_flag, m_flag); end
            if (fe_flag !== m_fe) begin n_fail++; $display("FAIL R5 fe_flag actual %0d expected %0d", fe_flag, m_fe); end
            if (int'(overrun_cnt) != m_ovr) begin n_fail++; $display("FAIL R10 overrun_cnt actual %0d expected %0d", overrun_cnt, m_ovr); end
            if (sh_rdata !== (sh_sel ? m_fe : m_mode9)) begin n_fail++; $display("FAIL R3 sh_rdata actual %0d expected %0d", sh_rdata, sh_sel ? m_fe : m_mode9); end
        end
    end

    task automatic drive_bit(input logic v);
        @(negedge clk) rxd = v;
        repeat (15) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_v);
        logic b9e, mp_on, hit, acc;
        cmp_en = 0;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (m_mode9) drive_bit(b9);
        drive_bit(stop_v);
        drive_bit(1'b1);
        drive_bit(1'b1);
        b9e   = m_mode9 ? b9 : stop_v;
        mp_on = m_mode9 && mp_en;
        hit   = (((d ^ ADDR) & MASK) == 8'h00) || ((d & (ADDR | MASK)) == (ADDR | MASK));
        acc   = !mp_on || (b9e ? hit : m_sel_node);
        if (mp_on && b9e) m_sel_node = hit;
        if (!stop_v) m_fe = 1;
        if (acc) begin
            if (m_flag) m_ovr = (m_ovr + 1) % (1 << OVR_W);
            else begin m_data = d; m_b9 = b9e; m_flag = 1; end
        end
        cmp_en = 1;
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1;
        @(posedge clk); #1 m_flag = 0;
        @(negedge clk) flag_clr = 0;
    endtask

    task automatic sh_write(input logic sel, input logic v);
        @(negedge clk) begin sh_sel = sel; sh_wr = 1; sh_wdata = v; end
        @(posedge clk); #1 if (sel) m_fe = v; else m_mode9 = v;
        @(negedge clk) sh_wr = 0;
    endtask

    task automatic set_mp(input logic v);
        @(negedge clk) mp_en = v;
        if (!v) m_sel_node = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 rx_flag", rx_flag, 0);
        chk("R1 fe_flag", fe_flag, 0);
        chk("R1 overrun_cnt", overrun_cnt, 0);
        chk("R1 sh_rdata", sh_rdata, 0);
        cmp_en = 1;

        // R2 eight-bit frame
        send_frame(8'hA5, 1'b0, 1'b1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 flag", rx_flag, 1);
        chk("R2 stop in bit9", rx_bit9, 1);

        // R10 overrun without overwrite
        send_frame(8'h3C, 1'b0, 1'b1);
        chk("R10 kept", rx_data, 8'hA5);
        chk("R10 count", overrun_cnt, 1);

        // R11 clear then receive
        clear_flag();
        chk("R11 cleared", rx_flag, 0);
        send_frame(8'h3C, 1'b0, 1'b1);
        chk("R2 second byte", rx_data, 8'h3C);
        clear_flag();

        // R5 framing error
        send_frame(8'h5A, 1'b0, 1'b0);
        chk("R5 fe set", fe_flag, 1);
        chk("R5 delivered", rx_data, 8'h5A);
        @(negedge clk) sh_sel = 1;
        @(negedge clk);
        chk("R5 shared reads fe", sh_rdata, 1);
        sh_write(1'b1, 1'b0);
        chk("R5 fe cleared", fe_flag, 0);
        clear_flag();

        // R4 glitch on the line
        @(negedge clk) rxd = 0;
        repeat (4) @(negedge clk);
        rxd = 1;
        repeat (40) @(negedge clk);
        chk("R4 no flag", rx_flag, 0);
        chk("R4 no data", rx_data, 8'h5A);

        // R3 nine-bit mode via shared bit with sel=0
        sh_write(1'b0, 1'b1);
        chk("R3 mode readback", sh_rdata, 1);
        send_frame(8'h81, 1'b1, 1'b1);
        chk("R3 ninth bit 1", rx_bit9, 1);
        clear_flag();
        send_frame(8'h42, 1'b0, 1'b1);
        chk("R3 ninth bit 0", rx_bit9, 0);
        chk("R3 data", rx_data, 8'h42);
        clear_flag();

        // multi-drop filtering
        set_mp(1'b1);
        send_frame(8'h11, 1'b0, 1'b1);
        chk("R9 data before select", rx_flag, 0);
        send_frame(8'h71, 1'b1, 1'b1);
        chk("R8 foreign address", rx_flag, 0);
        send_frame(8'hF9, 1'b1, 1'b1);
        chk("R6 own address", rx_flag, 1);
        chk("R6 own address data", rx_data, 8'hF9);
        clear_flag();
        send_frame(8'h22, 1'b0, 1'b1);
        chk("R9 data after select", rx_data, 8'h22);
        clear_flag();
        send_frame(8'h71, 1'b1, 1'b1);
        send_frame(8'h33, 1'b0, 1'b1);
        chk("R8 deselected", rx_flag, 0);
        send_frame(8'hF4, 1'b1, 1'b1);
        chk("R7 one bit short", rx_flag, 0);
        send_frame(8'hFF, 1'b1, 1'b1);
        chk("R7 broadcast", rx_data, 8'hFF);
        clear_flag();
        send_frame(8'hF5, 1'b1, 1'b1);
        chk("R7 exact pattern", rx_data, 8'hF5);
        clear_flag();
        set_mp(1'b0);
        set_mp(1'b1);
        send_frame(8'h44, 1'b0, 1'b1);
        chk("R9 cleared by mp_en", rx_flag, 0);

        // R10 wrap of the counter
        set_mp(1'b0);
        send_frame(8'h01, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) send_frame(8'h02, 1'b0, 1'b1);
        chk("R10 wrap", overrun_cnt, 0);
        chk("R10 buffer kept", rx_data, 8'h01);

        repeat (4) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule